// File: doc/BRIEF.md
# Cascaded Up/Down Timer Pair with Toggle Link

This block joins two equal-width up/down counters through one toggle flip-flop. The first counter, the core stage, advances on a count tick, on a gated tick, or on rising edges of an external input, depending on a mode select. Each time the core stage wraps, in either direction, it inverts the toggle bit. The second counter, the auxiliary stage, advances on edges of that toggle bit that a link select chooses.

When both toggle edges are enabled, the auxiliary stage moves once per core wrap and the pair behaves as a counter two stages wide. When a single edge polarity is enabled, the auxiliary stage moves once every second core wrap, so the toggle bit acts as one extra middle bit and the chain is one bit wider. Each stage has its own direction input. Each stage drives a registered one-cycle wrap pulse.

Top module: `cascade_timer`

## Requirements
- R1: A synchronous active-high reset clears both counts, the toggle bit and both wrap pulses to zero.
- R2: In mode 2'b00 (free timer) the core count changes by one, upward when `core_dn`=0 and downward when `core_dn`=1, on each clock where `tick` is high, and holds when `tick` is low. In mode 2'b11 the core count holds.
- R3: In mode 2'b01 (gated timer) the core count steps only on clocks where both `tick` and `gate` are high.
- R4: In mode 2'b10 (external counter) the core count steps once per rising edge of `ext_in`, judged against the level `ext_in` had on the previous clock, and `tick` has no effect.
- R5: The core stage wraps from all ones to zero when counting up and from zero to all ones when counting down. On that same clock edge the toggle bit inverts and `core_wrap` goes high for exactly one cycle.
- R6: With `link_sel`=2'b11 the auxiliary count steps once for every toggle change, one clock after the toggle bit changes.
- R7: With `link_sel`=2'b01 the auxiliary count steps only after a 0-to-1 toggle change, and with 2'b10 only after a 1-to-0 change. The chain then counts every second core wrap.
- R8: With `link_sel`=2'b00 the auxiliary count holds whatever the toggle bit does.
- R9: The auxiliary stage counts in the direction set by `aux_dn`, independently of `core_dn`. It wraps like the core stage and raises `aux_wrap` for one cycle on its wrap edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| core_mode | input | 2 | Core source: 00 free, 01 gated, 10 external edge, 11 stopped |
| tick | input | 1 | Count enable or prescaled tick for the core stage |
| gate | input | 1 | Gate level for gated mode, active high |
| ext_in | input | 1 | External event input for counter mode |
| core_dn | input | 1 | Core direction, 1 = down |
| aux_dn | input | 1 | Auxiliary direction, 1 = down |
| link_sel | input | 2 | Toggle edges that step the auxiliary stage: 00 none, 01 rising, 10 falling, 11 both |
| core_count | output | WIDTH | Core stage value |
| aux_count | output | WIDTH | Auxiliary stage value |
| toggle_bit | output | 1 | Link toggle bit |
| core_wrap | output | 1 | One-cycle core wrap pulse |
| aux_wrap | output | 1 | One-cycle auxiliary wrap pulse |

## Verification
On every cycle the assertions check that the core value moves by at most one step, that a core wrap pulse comes with a toggle change and lands on the correct end value, that the auxiliary stage moves only in the cycle after a toggle change, and that it holds with the link off. The exact counts, the 32-bit versus 33-bit ratio, how gate and external edges qualify steps, and the wrap pulses of both stages in every direction pairing can only be shown by the bench sweeps. Those sweeps run a narrow configuration through several full auxiliary revolutions and compare each cycle against closed-form arithmetic on the number of qualifying core events.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_GATED = 2'b01,
    MODE_EXT   = 2'b10,
    MODE_HOLD  = 2'b11
  } core_mode_e;

  typedef enum logic [1:0] {
    LINK_OFF  = 2'b00,
    LINK_RISE = 2'b01,
    LINK_FALL = 2'b10,
    LINK_BOTH = 2'b11
  } link_sel_e;
endpackage

// File: rtl/core_step_sel.sv
module core_step_sel
  import cascade_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  core_mode_e mode,
  input  logic       tick,
  input  logic       gate,
  input  logic       ext_in,
  output logic       step
);
  logic ext_q;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext_in;
  end

  always_comb begin
    unique case (mode)
      MODE_FREE:  step = tick;
      MODE_GATED: step = tick & gate;
      MODE_EXT:   step = ext_in & ~ext_q;
      default:    step = 1'b0;
    endcase
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             down,
  output logic [WIDTH-1:0] count,
  output logic             carry,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  // carry is the combinational wrap condition for this edge
  assign carry = step & (down ? (count == '0) : (count == ALL_ONES));

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= carry;
      if (step) count <= down ? count - ONE : count + ONE;
    end
  end
endmodule

// File: rtl/toggle_link.sv
module toggle_link
  import cascade_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flip,
  input  link_sel_e sel,
  output logic      toggle,
  output logic      aux_step
);
  logic toggle_q;
  logic rose;
  logic fell;

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle   <= 1'b0;
      toggle_q <= 1'b0;
    end else begin
      toggle   <= toggle ^ flip;
      toggle_q <= toggle;
    end
  end

  assign rose = toggle & ~toggle_q;
  assign fell = ~toggle & toggle_q;

  always_comb begin
    unique case (sel)
      LINK_RISE: aux_step = rose;
      LINK_FALL: aux_step = fell;
      LINK_BOTH: aux_step = rose | fell;
      default:   aux_step = 1'b0;
    endcase
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       core_mode,
  input  logic             tick,
  input  logic             gate,
  input  logic             ext_in,
  input  logic             core_dn,
  input  logic             aux_dn,
  input  logic [1:0]       link_sel,
  output logic [WIDTH-1:0] core_count,
  output logic [WIDTH-1:0] aux_count,
  output logic             toggle_bit,
  output logic             core_wrap,
  output logic             aux_wrap
);
  logic core_step;
  logic core_carry;
  logic aux_step;
  logic aux_carry;

  core_step_sel u_sel (
    .clk   (clk),
    .rst   (rst),
    .mode  (core_mode_e'(core_mode)),
    .tick  (tick),
    .gate  (gate),
    .ext_in(ext_in),
    .step  (core_step)
  );

  wrap_counter #(.WIDTH(WIDTH)) u_core (
    .clk  (clk),
    .rst  (rst),
    .step (core_step),
    .down (core_dn),
    .count(core_count),
    .carry(core_carry),
    .wrap (core_wrap)
  );

  toggle_link u_link (
    .clk     (clk),
    .rst     (rst),
    .flip    (core_carry),
    .sel     (link_sel_e'(link_sel)),
    .toggle  (toggle_bit),
    .aux_step(aux_step)
  );

  wrap_counter #(.WIDTH(WIDTH)) u_aux (
    .clk  (clk),
    .rst  (rst),
    .step (aux_step),
    .down (aux_dn),
    .count(aux_count),
    .carry(aux_carry),
    .wrap (aux_wrap)
  );
endmodule

// File: rtl/cascade_timer_checker.sv
module cascade_timer_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             core_dn,
  input logic             aux_dn,
  input logic [1:0]       link_sel,
  input logic [WIDTH-1:0] core_count,
  input logic [WIDTH-1:0] aux_count,
  input logic             toggle_bit,
  input logic             core_wrap,
  input logic             aux_wrap
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (core_count == $past(core_count)) ||
    (core_count == $past(core_count) + ONE) ||
    (core_count == $past(core_count) - ONE));

  assert_wrap_flips_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    core_wrap |-> (toggle_bit != $past(toggle_bit)));

  assert_up_wrap_end_R5: assert property (@(posedge clk) disable iff (rst)
    (core_wrap && !$past(core_dn)) |-> (core_count == '0));

  assert_down_wrap_end_R5: assert property (@(posedge clk) disable iff (rst)
    (core_wrap && $past(core_dn)) |-> (core_count == ALL_ONES));

  assert_both_edges_step_R6: assert property (@(posedge clk) disable iff (rst)
    (link_sel == 2'b11 && toggle_bit != $past(toggle_bit)) |=> (aux_count != $past(aux_count)));

  assert_aux_moves_after_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    (aux_count != $past(aux_count)) |-> ($past(toggle_bit) != $past(toggle_bit, 2)));

  assert_link_off_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (link_sel == 2'b00) |=> $stable(aux_count));

  assert_aux_wrap_end_R9: assert property (@(posedge clk) disable iff (rst)
    aux_wrap |-> (aux_count == ($past(aux_dn) ? ALL_ONES : '0)));
endmodule

bind cascade_timer cascade_timer_checker #(.WIDTH(WIDTH)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .core_dn   (core_dn),
  .aux_dn    (aux_dn),
  .link_sel  (link_sel),
  .core_count(core_count),
  .aux_count (aux_count),
  .toggle_bit(toggle_bit),
  .core_wrap (core_wrap),
  .aux_wrap  (aux_wrap)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   core_mode = 2'b00;
  logic         tick = 1'b0;
  logic         gate = 1'b0;
  logic         ext_in = 1'b0;
  logic         core_dn = 1'b0;
  logic         aux_dn = 1'b0;
  logic [1:0]   link_sel = 2'b00;
  logic [W-1:0] core_count;
  logic [W-1:0] aux_count;
  logic         toggle_bit;
  logic         core_wrap;
  logic         aux_wrap;

  cascade_timer #(.WIDTH(W)) u_cascade_timer (
    .clk       (clk),
    .rst       (rst),
    .core_mode (core_mode),
    .tick      (tick),
    .gate      (gate),
    .ext_in    (ext_in),
    .core_dn   (core_dn),
    .aux_dn    (aux_dn),
    .link_sel  (link_sel),
    .core_count(core_count),
    .aux_count (aux_count),
    .toggle_bit(toggle_bit),
    .core_wrap (core_wrap),
    .aux_wrap  (aux_wrap)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // number of core wraps after n qualifying steps from zero
  function automatic int wraps(int n, bit dn);
    return dn ? (n + M - 1) / M : n / M;
  endfunction

  // number of auxiliary steps produced by w toggle changes
  function automatic int aux_events(int w, int link);
    case (link)
      1:       return (w + 1) / 2;
      2:       return w / 2;
      3:       return w;
      default: return 0;
    endcase
  endfunction

  function automatic int value_of(int e, bit dn);
    return dn ? (M - (e % M)) % M : e % M;
  endfunction

  task automatic run(int mode, int link, bit cdn, bit adn, int pat, int cycles);
    int n = 0, np = 0, npp = 0;
    bit ext_prev = 1'b0;
    string ctag, atag;
    ctag = (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R2";
    atag = (link == 0) ? "R8" : (link == 3) ? "R6" : "R7";
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; gate = 1'b0; ext_in = 1'b0;
    core_mode = 2'(mode); link_sel = 2'(link); core_dn = cdn; aux_dn = adn;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 core_count", int'(core_count), 0);
    check("R1 aux_count", int'(aux_count), 0);
    check("R1 toggle_bit", int'(toggle_bit), 0);
    check("R1 wraps", int'({core_wrap, aux_wrap}), 0);
    for (int i = 0; i < cycles; i++) begin
      bit tk, g, e, q;
      if (pat == 0) begin
        tk = 1'b1; g = 1'b1; e = i[0];
      end else begin
        tk = (i % 3) != 0; g = ((i / 5) % 2) == 0; e = ((i / 3) % 2) == 1;
      end
      case (mode)
        0:       q = tk;
        1:       q = tk & g;
        2:       q = e & ~ext_prev;
        default: q = 1'b0;
      endcase
      ext_prev = e;
      tick = tk; gate = g; ext_in = e;
      @(negedge clk);
      npp = np; np = n;
      if (q) n++;
      check({ctag, " core_count"}, int'(core_count), value_of(n, cdn));
      check("R5 toggle_bit", int'(toggle_bit), wraps(n, cdn) % 2);
      check("R5 core_wrap", int'(core_wrap), int'(wraps(n, cdn) != wraps(np, cdn)));
      begin
        int e1, e0;
        bit exp_w;
        e1 = aux_events(wraps(np, cdn), link);
        e0 = aux_events(wraps(npp, cdn), link);
        check({atag, " aux_count"}, int'(aux_count), value_of(e1, adn));
        exp_w = (e1 != e0) && (adn ? (e0 % M == 0) : (e1 % M == 0));
        check("R9 aux_wrap", int'(aux_wrap), int'(exp_w));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R6, R7, R8, R9: every link choice with every direction pairing, free running
    for (int link = 0; link < 4; link++)
      for (int d = 0; d < 4; d++)
        run(0, link, d[0], d[1], 0, 2 * M * M + 3 * M);
    // R2: free mode with an irregular tick
    run(0, 3, 1'b0, 1'b1, 1, 300);
    // R3: gated mode, tick and gate patterns independent
    run(1, 1, 1'b0, 1'b0, 1, 400);
    run(1, 3, 1'b1, 1'b0, 0, 200);
    // R4: external edges counted, tick pattern irrelevant
    run(2, 3, 1'b0, 1'b0, 0, 300);
    run(2, 2, 1'b1, 1'b1, 1, 400);
    // R2: stopped mode holds
    run(3, 3, 1'b0, 1'b0, 0, 50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule